// File: doc/BRIEF.md
# Cascadable Signed/Unsigned Magnitude Comparator

This block decides whether a word P is greater than, less than or equal to a word Q. It reports the result on two decoded outputs: greater and less. Equality is shown by both outputs being low. A mode input picks an unsigned comparison or a two's-complement comparison. In two's-complement mode the top bit is the sign.

The P operand passes through a level-sensitive holding latch. The latch is open while its enable is high and keeps the last P word while the enable is low. An active-low asynchronous reset clears the held word to zero.

Two cascade inputs carry the verdict of a less significant stage, so stages chain to any width. The lowest stage ties its cascade inputs low and runs in unsigned mode. Only the top stage of a chain may select two's-complement mode. The path from the held P word and Q to the outputs is purely combinational.

Top module: `cmp_mag_cascade`

## Requirements
- R1: While `le_i` is 1 and reset is released, the held P word follows `p_i` in the same evaluation.
- R2: While `le_i` is 0, changes on `p_i` have no effect on the outputs; the last held word is used.
- R3: While `rst_ni` is 0 the held P word is zero, whatever `le_i` and `p_i` are; with `le_i` at 0 it stays zero after reset is released.
- R4: With `arith_i` = 0 the words are compared as unsigned numbers: `gt_o`=1,`lt_o`=0 when P>Q, and `gt_o`=0,`lt_o`=1 when P<Q.
- R5: With `arith_i` = 1 the words are compared as two's-complement numbers, with bit WIDTH-1 as the sign.
- R6: When the local words differ, the cascade inputs have no effect on the outputs.
- R7: When the local words are equal, `gt_o` copies `gt_i` and `lt_o` copies `lt_i`; both cascade inputs low gives both outputs low (equal).
- R8: When the words are equal and both cascade inputs are 1, both outputs are 1; this invalid code passes through unchanged.
- R9: `gt_o` and `lt_o` are never both 1 unless `gt_i` and `lt_i` are both 1.
- R10: Two stages, the lower in unsigned mode with its cascade inputs tied low and feeding the upper stage's cascade inputs, give the correct 2*WIDTH-bit unsigned or signed result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Active-low asynchronous clear of the held P word |
| le_i | input | 1 | P latch enable: 1 passes P through, 0 holds it |
| arith_i | input | 1 | 1 selects two's-complement comparison, 0 selects unsigned |
| p_i | input | WIDTH | P operand, before the latch |
| q_i | input | WIDTH | Q operand |
| gt_i | input | 1 | Greater verdict from the less significant stage |
| lt_i | input | 1 | Less verdict from the less significant stage |
| gt_o | output | 1 | P greater than Q |
| lt_o | output | 1 | P less than Q |

## Verification
The bench builds the block with the default WIDTH of 8. That keeps the sign boundary at 0x7F/0x80 easy to aim at, and it lets random vectors land on equal words often enough to exercise the cascade pass-through. A second build joins two 8-bit stages into a 16-bit chain. In that build, equal upper bytes make the verdict depend entirely on the lower stage, in both signed and unsigned mode. Latch hold and reset clear are shown only through the outputs: the bench compares the held value against a chosen Q and watches whether the cascade inputs appear at the outputs.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
  } verdict_t;

  localparam verdict_t VERDICT_EQ = '{gt: 1'b0, lt: 1'b0};
endpackage

// File: rtl/cmp_p_latch.sv
module cmp_p_latch #(
  parameter int WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (le_i) q_o = d_i;
  end
endmodule

// File: rtl/cmp_word_core.sv
module cmp_word_core
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             arith_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output verdict_t         res_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bit_gt, bit_lt;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == MSB) begin : g_sign
        // in arithmetic mode a set top bit means negative, so the sense flips
        assign bit_gt[i] = arith_i ? (~a_i[i] & b_i[i]) : (a_i[i] & ~b_i[i]);
        assign bit_lt[i] = arith_i ? (a_i[i] & ~b_i[i]) : (~a_i[i] & b_i[i]);
      end else begin : g_mag
        assign bit_gt[i] = a_i[i] & ~b_i[i];
        assign bit_lt[i] = ~a_i[i] & b_i[i];
      end
    end
  endgenerate

  // first differing bit from the top decides
  always_comb begin
    res_o = VERDICT_EQ;
    for (int k = 0; k < WIDTH; k++) begin
      if (bit_gt[k] || bit_lt[k]) begin
        res_o.gt = bit_gt[k];
        res_o.lt = bit_lt[k];
      end
    end
  end
endmodule

// File: rtl/cmp_cascade_merge.sv
module cmp_cascade_merge
  import cmp_pkg::*;
(
  input  verdict_t local_i,
  input  verdict_t casc_i,
  output verdict_t res_o
);
  logic local_eq;
  assign local_eq = ~(local_i.gt | local_i.lt);
  assign res_o    = local_eq ? casc_i : local_i;
endmodule

// File: rtl/cmp_mag_cascade.sv
module cmp_mag_cascade
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             arith_i,
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             gt_i,
  input  logic             lt_i,
  output logic             gt_o,
  output logic             lt_o
);
  logic [WIDTH-1:0] p_held;
  verdict_t         local_res, casc_res, final_res;

  cmp_p_latch #(.WIDTH(WIDTH)) u_latch (
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .d_i    (p_i),
    .q_o    (p_held)
  );

  cmp_word_core #(.WIDTH(WIDTH)) u_core (
    .arith_i (arith_i),
    .a_i     (p_held),
    .b_i     (q_i),
    .res_o   (local_res)
  );

  assign casc_res.gt = gt_i;
  assign casc_res.lt = lt_i;

  cmp_cascade_merge u_merge (
    .local_i (local_res),
    .casc_i  (casc_res),
    .res_o   (final_res)
  );

  assign gt_o = final_res.gt;
  assign lt_o = final_res.lt;
endmodule

// File: rtl/cmp_mag_cascade_chk.sv
module cmp_mag_cascade_chk #(
  parameter int WIDTH = 8
) (
  input logic             rst_ni,
  input logic             le_i,
  input logic             arith_i,
  input logic [WIDTH-1:0] p_i,
  input logic [WIDTH-1:0] q_i,
  input logic             gt_i,
  input logic             lt_i,
  input logic             gt_o,
  input logic             lt_o,
  input logic [WIDTH-1:0] p_held
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (p_held == '0); // R3
    end else begin
      if (le_i) begin
        AST_LATCH_OPEN: assert (p_held == p_i); // R1
      end
      if (!(gt_i && lt_i)) begin
        AST_NOT_BOTH: assert (!(gt_o && lt_o)); // R9
      end
      if (p_held == q_i) begin
        AST_EQ_FOLLOWS_CASC: assert (gt_o == gt_i && lt_o == lt_i); // R7
      end
      if (!arith_i && p_held > q_i) begin
        AST_UNSIGNED_GT: assert (gt_o && !lt_o); // R4
      end
      if (arith_i && $signed(p_held) < $signed(q_i)) begin
        AST_SIGNED_LT: assert (lt_o && !gt_o); // R5
      end
    end
  end
endmodule

bind cmp_mag_cascade cmp_mag_cascade_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_ni  (rst_ni),
  .le_i    (le_i),
  .arith_i (arith_i),
  .p_i     (p_i),
  .q_i     (q_i),
  .gt_i    (gt_i),
  .lt_i    (lt_i),
  .gt_o    (gt_o),
  .lt_o    (lt_o),
  .p_held  (p_held)
);

// File: tb/cmp_mag_cascade_test.sv
`timescale 1ns/1ps
module cmp_mag_cascade_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_ni, le_i, arith_i, gt_i, lt_i;
  logic [W-1:0] p_i, q_i;
  logic         gt_o, lt_o;

  logic          c_le, c_arith;
  logic [2*W-1:0] c_p, c_q;
  logic          lo_gt, lo_lt, hi_gt, hi_lt;

  int checks = 0;
  int fails  = 0;
  int p_store = 0;

  cmp_mag_cascade #(.WIDTH(W)) uut (
    .rst_ni(rst_ni), .le_i(le_i), .arith_i(arith_i), .p_i(p_i), .q_i(q_i),
    .gt_i(gt_i), .lt_i(lt_i), .gt_o(gt_o), .lt_o(lt_o));

  cmp_mag_cascade #(.WIDTH(W)) chain_lo (
    .rst_ni(rst_ni), .le_i(c_le), .arith_i(1'b0), .p_i(c_p[W-1:0]), .q_i(c_q[W-1:0]),
    .gt_i(1'b0), .lt_i(1'b0), .gt_o(lo_gt), .lt_o(lo_lt));

  cmp_mag_cascade #(.WIDTH(W)) chain_hi (
    .rst_ni(rst_ni), .le_i(c_le), .arith_i(c_arith), .p_i(c_p[2*W-1:W]), .q_i(c_q[2*W-1:W]),
    .gt_i(lo_gt), .lt_i(lo_lt), .gt_o(hi_gt), .lt_o(hi_lt));

  function automatic int to_val(int v, int bits, bit signed_mode);
    if (signed_mode && v >= (1 << (bits - 1))) return v - (1 << bits);
    return v;
  endfunction

  function automatic logic [1:0] ref_cmp(int p, int q, int bits, bit signed_mode,
                                         logic g, logic l);
    int pv = to_val(p, bits, signed_mode);
    int qv = to_val(q, bits, signed_mode);
    if (pv > qv) return 2'b10;
    if (pv < qv) return 2'b01;
    return {g, l};
  endfunction

  task automatic drive(logic rst, logic le, logic ar, int p, int q, logic g, logic l);
    @(posedge clk);
    rst_ni = rst; le_i = le; arith_i = ar; p_i = p[W-1:0]; q_i = q[W-1:0];
    gt_i = g; lt_i = l;
    if (!rst)    p_store = 0;
    else if (le) p_store = p & ((1 << W) - 1);
  endtask

  task automatic check(string tag);
    logic [1:0] exp;
    @(negedge clk);
    exp = ref_cmp(p_store, int'(q_i), W, arith_i, gt_i, lt_i);
    checks++;
    if ({gt_o, lt_o} !== exp) begin
      fails++;
      $display("FAIL %s: actual gt/lt=%b%b expected %b%b (p=%0d q=%0d ar=%b)",
               tag, gt_o, lt_o, exp[1], exp[0], p_store, q_i, arith_i);
    end
  endtask

  task automatic check_chain(string tag);
    logic [1:0] exp;
    @(negedge clk);
    exp = ref_cmp(int'(c_p), int'(c_q), 2 * W, c_arith, 1'b0, 1'b0);
    checks++;
    if ({hi_gt, hi_lt} !== exp) begin
      fails++;
      $display("FAIL %s: actual gt/lt=%b%b expected %b%b (p=%h q=%h ar=%b)",
               tag, hi_gt, hi_lt, exp[1], exp[0], c_p, c_q, c_arith);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; le_i = 1'b0; arith_i = 1'b0; p_i = '0; q_i = '0;
    gt_i = 1'b0; lt_i = 1'b0;
    c_le = 1'b1; c_arith = 1'b0; c_p = '0; c_q = '0;

    // R3: reset clears held word even with latch open
    drive(1'b0, 1'b1, 1'b0, 8'hFF, 0, 1'b1, 1'b0); check("R3 reset open");
    drive(1'b0, 1'b0, 1'b0, 8'hA5, 0, 1'b0, 1'b1); check("R3 reset closed");
    drive(1'b1, 1'b0, 1'b0, 8'hA5, 0, 1'b1, 1'b0); check("R3 after release");

    // R1 / R2: transparent then hold
    drive(1'b1, 1'b1, 1'b0, 8'h3C, 8'h3C, 1'b0, 1'b0); check("R1 open equal");
    drive(1'b1, 1'b1, 1'b0, 8'h50, 8'h3C, 1'b0, 1'b0); check("R1 open follows");
    drive(1'b1, 1'b0, 1'b0, 8'h00, 8'h50, 1'b0, 1'b1); check("R2 hold ignores p");
    drive(1'b1, 1'b0, 1'b0, 8'hFF, 8'h50, 1'b1, 1'b0); check("R2 hold ignores p again");

    // R4 / R5 sign boundary
    drive(1'b1, 1'b1, 1'b0, 8'h80, 8'h7F, 1'b0, 1'b0); check("R4 unsigned 80>7F");
    drive(1'b1, 1'b1, 1'b1, 8'h80, 8'h7F, 1'b0, 1'b0); check("R5 signed 80<7F");
    drive(1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 1'b0); check("R5 signed -1<0");
    drive(1'b1, 1'b1, 1'b1, 8'hFE, 8'hFF, 1'b0, 1'b0); check("R5 signed -2<-1");

    // R6 cascade ignored when unequal
    drive(1'b1, 1'b1, 1'b0, 8'h10, 8'h20, 1'b1, 1'b0); check("R6 unequal casc gt");
    drive(1'b1, 1'b1, 1'b1, 8'h20, 8'h10, 1'b1, 1'b1); check("R6 unequal casc both");

    // R7 / R8 equal words
    drive(1'b1, 1'b1, 1'b0, 8'h77, 8'h77, 1'b0, 1'b0); check("R7 equal eq");
    drive(1'b1, 1'b1, 1'b1, 8'h77, 8'h77, 1'b1, 1'b0); check("R7 equal gt");
    drive(1'b1, 1'b1, 1'b0, 8'h77, 8'h77, 1'b0, 1'b1); check("R7 equal lt");
    drive(1'b1, 1'b1, 1'b0, 8'h99, 8'h99, 1'b1, 1'b1); check("R8 invalid passes");

    // R4 R5 R9 random, frequent equality
    for (int n = 0; n < 3000; n++) begin
      int p = $urandom_range(0, 255);
      int q = ($urandom_range(0, 3) == 0) ? p : $urandom_range(0, 255);
      drive(1'b1, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), p, q,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check("R4/R5/R9 random");
    end

    // R10 16-bit chain
    drive(1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    for (int n = 0; n < 2000; n++) begin
      @(posedge clk);
      c_arith = 1'($urandom_range(0, 1));
      c_p = 16'($urandom_range(0, 65535));
      c_q = ($urandom_range(0, 2) == 0) ? {c_p[15:8], 8'($urandom_range(0, 255))}
                                        : 16'($urandom_range(0, 65535));
      if (n % 50 == 0) c_q = c_p;
      check_chain("R10 chain");
    end
    @(posedge clk); c_arith = 1'b1; c_p = 16'h8000; c_q = 16'h7FFF;
    check_chain("R10 chain signed min<max");
    @(posedge clk); c_arith = 1'b0;
    check_chain("R10 chain unsigned 8000>7FFF");
    @(posedge clk); c_arith = 1'b1; c_p = 16'h12FF; c_q = 16'h1200;
    check_chain("R10 chain low byte decides");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule